// File: doc/BRIEF.md
# Virtual-Channel Input Controller for a Two-Stage Router

This block is the input logic of one virtual channel in a two-stage virtual-channel router. Flits arrive into a small queue. When a head flit reaches the front of the queue, the first stage computes its route with a dimension-ordered lookup, X before Y. The result goes into per-channel control registers only; the flit itself does not move. In the next cycle the second stage requests a downstream virtual channel and a switch slot for the head. The head leaves only when both are granted in the same cycle.

Body and tail flits reuse the stored output port and output channel. They are dequeued whenever the switch grant arrives. When the tail leaves, the packet's state is cleared. The next head in the same queue can only compute its route in the following cycle, so each packet boundary costs one idle output cycle.

The allocators and the crossbar lie outside the block. The environment supplies a one-hot channel grant and a one-bit switch grant. The upstream sender tracks queue space through a registered credit pulse.

Top module: `vc_input_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `va_req`, `sa_req` and `deq` are 0, `req_port` and `req_vc` are 0, `credit_out` is 0 and `in_full` is 0.
- R2: The queue holds 4 flits, in arrival order. `in_full` is 1 exactly when 4 flits are held. A flit is written when `in_valid` is 1 and the queue is not full. Flit layout: bit 15 is head, bit 14 is tail, bits 13:11 are destination X, bits 10:8 are destination Y, bits 7:0 are payload. A body flit has both type bits at 0. A single-flit packet has both at 1.
- R3: The route is computed from the router position (3,3) and is one-hot on `req_port`. The order of checks is: destination X greater gives bit 1 (east); destination X smaller gives bit 2 (west); otherwise destination Y greater gives bit 3 (north); destination Y smaller gives bit 4 (south); otherwise bit 0 (local). `req_port` is 0 whenever no request is raised.
- R4: In the cycle a head first sits at the queue front, route computation runs and no request is raised. From the next cycle on, `va_req` and `sa_req` are both 1 with the computed port.
- R5: While a head is waiting for allocation, it is dequeued only in a cycle where `va_grant` is nonzero and `sa_grant` is 1. In that cycle `req_vc` shows the index of the granted channel. A channel grant without a switch grant stores that index and leaves the head at the front. A switch grant without a channel grant has no effect.
- R6: Once a channel is held, the front flit raises `sa_req` (not `va_req`) with the stored port and channel. It is dequeued when `sa_grant` is 1. Without a grant, the same request repeats unchanged in the next cycle.
- R7: When a tail flit is dequeued, the port and channel are released. In the next cycle no request is raised, even if a head already waits at the front.
- R8: `credit_out` is 1 in the cycle after each dequeue, and 0 otherwise.
- R9: While `deq` is 1, `out_flit` equals the flit at the queue front.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming flit strobe |
| in_flit | input | 16 | Incoming flit |
| in_full | output | 1 | Queue holds 4 flits |
| credit_out | output | 1 | Registered credit pulse, one per dequeue |
| va_req | output | 1 | Head requests a downstream channel |
| sa_req | output | 1 | Switch request |
| req_port | output | 5 | One-hot output port of the request |
| req_vc | output | 2 | Output channel index of the request |
| va_grant | input | 4 | One-hot downstream channel grant |
| sa_grant | input | 1 | Switch grant |
| deq | output | 1 | Front flit leaves this cycle |
| out_flit | output | 16 | Flit sent to the crossbar |

## Verification
The bench targets several cases at packet edges:
- A head that arrives right behind a departing tail. A design that skipped the idle cycle would raise a request with the previous packet's port.
- A channel grant without a switch grant. A design that lost the stored channel would change `req_vc` in the next cycle.
- A switch grant without a channel grant. A design that honoured it would drop a head that had no channel.
- Single-flit packets, whose head is also the tail. The bench checks that they release the state at once.
- A queue filled with all grants withheld. This shows whether `in_full` and write blocking match exactly four entries.

// File: rtl/vcic_pkg.sv
// Package: shared types of the virtual-channel input controller.
// Assumes one-hot output-port encoding, five router ports.
package vcic_pkg;
    localparam int NUM_PORTS = 5;
    localparam int P_LOCAL   = 0;
    localparam int P_EAST    = 1;
    localparam int P_WEST    = 2;
    localparam int P_NORTH   = 3;
    localparam int P_SOUTH   = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROUTED = 2'd1,
        ST_ACTIVE = 2'd2
    } vc_state_t;
endpackage

// File: rtl/vcic_fifo.sv
// Module: vcic_fifo
// Flit queue of one virtual channel. Writes are dropped when full; reads are
// ignored when empty. Assumes DEPTH is a power of two.
module vcic_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] front,
    output logic              empty,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] store [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [AW:0]       count;
    logic              do_wr;
    logic              do_rd;

    assign empty = (count == '0);
    assign full  = (count == (AW+1)'(DEPTH));
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;
    assign front = store[rd_ptr];

    // Storage write: no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_wr) store[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full); // R2
endmodule

// File: rtl/vcic_route.sv
// Module: vcic_route
// Dimension-ordered route lookup, X first, then Y. Purely combinational.
// Assumes unsigned mesh coordinates.
module vcic_route
    import vcic_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int CUR_X   = 3,
    parameter int CUR_Y   = 3
) (
    input  logic [COORD_W-1:0]   dest_x,
    input  logic [COORD_W-1:0]   dest_y,
    output logic [NUM_PORTS-1:0] port
);
    localparam logic [COORD_W-1:0] HERE_X = COORD_W'(CUR_X);
    localparam logic [COORD_W-1:0] HERE_Y = COORD_W'(CUR_Y);

    // Pick one output port, resolving X before Y.
    always_comb begin
        port = '0;
        if (dest_x > HERE_X)      port[P_EAST]  = 1'b1;
        else if (dest_x < HERE_X) port[P_WEST]  = 1'b1;
        else if (dest_y > HERE_Y) port[P_NORTH] = 1'b1;
        else if (dest_y < HERE_Y) port[P_SOUTH] = 1'b1;
        else                      port[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/vcic_ctrl.sv
// Module: vcic_ctrl
// Per-packet control of one virtual channel: holds the routed port and the
// allocated output channel, raises requests, decides dequeue.
// Assumes va_grant has at most one bit set; the lowest set bit wins otherwise.
module vcic_ctrl
    import vcic_pkg::*;
#(
    parameter int NUM_OVC = 4,
    parameter int VC_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 front_valid,
    input  logic                 front_head,
    input  logic                 front_tail,
    input  logic [NUM_PORTS-1:0] rc_port,
    input  logic [NUM_OVC-1:0]   va_grant,
    input  logic                 sa_grant,
    output logic                 va_req,
    output logic                 sa_req,
    output logic [NUM_PORTS-1:0] req_port,
    output logic [VC_W-1:0]      req_vc,
    output logic                 deq
);
    vc_state_t            state;
    logic [NUM_PORTS-1:0] port_q;
    logic [VC_W-1:0]      vc_q;
    logic                 va_hit;
    logic [VC_W-1:0]      va_idx;

    assign va_hit = |va_grant;

    // Encode the channel grant, lowest index first.
    always_comb begin
        va_idx = '0;
        for (int i = NUM_OVC - 1; i >= 0; i--) begin
            if (va_grant[i]) va_idx = VC_W'(i);
        end
    end

    // Request and dequeue decision for the current state.
    always_comb begin
        va_req   = 1'b0;
        sa_req   = 1'b0;
        req_port = '0;
        req_vc   = '0;
        deq      = 1'b0;
        case (state)
            ST_ROUTED: begin
                va_req   = 1'b1;
                sa_req   = 1'b1;
                req_port = port_q;
                req_vc   = va_idx;
                deq      = va_hit && sa_grant;
            end
            ST_ACTIVE: begin
                if (front_valid) begin
                    sa_req   = 1'b1;
                    req_port = port_q;
                    req_vc   = vc_q;
                    deq      = sa_grant;
                end
            end
            default: ;
        endcase
    end

    // Per-packet state: route capture, channel capture, release on tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            port_q <= '0;
            vc_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (front_valid && front_head) begin
                        state  <= ST_ROUTED;
                        port_q <= rc_port;
                    end
                end
                ST_ROUTED: begin
                    if (deq && front_tail) begin
                        state  <= ST_IDLE;
                        port_q <= '0;
                        vc_q   <= '0;
                    end else if (va_hit) begin
                        state <= ST_ACTIVE;
                        vc_q  <= va_idx;
                    end
                end
                ST_ACTIVE: begin
                    if (deq && front_tail) begin
                        state  <= ST_IDLE;
                        port_q <= '0;
                        vc_q   <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (va_req || sa_req) |-> $onehot(req_port)); // R3
    AST_DEQ_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> (sa_grant && front_valid)); // R5
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && sa_req && !sa_grant)
        |=> (sa_req && $stable(req_port) && $stable(req_vc))); // R6
    AST_IDLE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (deq && front_tail) |=> (!sa_req && !va_req)); // R7
endmodule

// File: rtl/vc_input_ctrl.sv
// Module: vc_input_ctrl
// Top of one virtual-channel input: queue, route lookup, control registers
// and registered credit return. Flit: {head, tail, dest_x, dest_y, payload}.
// Assumes the sender never writes while in_full is set.
module vc_input_ctrl
    import vcic_pkg::*;
#(
    parameter int COORD_W   = 3,
    parameter int PAYLOAD_W = 8,
    parameter int DEPTH     = 4,
    parameter int NUM_OVC   = 4,
    parameter int CUR_X     = 3,
    parameter int CUR_Y     = 3,
    localparam int FLIT_W   = 2 + 2 * COORD_W + PAYLOAD_W,
    localparam int VC_W     = (NUM_OVC > 1) ? $clog2(NUM_OVC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [FLIT_W-1:0]    in_flit,
    output logic                 in_full,
    output logic                 credit_out,
    output logic                 va_req,
    output logic                 sa_req,
    output logic [NUM_PORTS-1:0] req_port,
    output logic [VC_W-1:0]      req_vc,
    input  logic [NUM_OVC-1:0]   va_grant,
    input  logic                 sa_grant,
    output logic                 deq,
    output logic [FLIT_W-1:0]    out_flit
);
    localparam int HEAD_BIT = FLIT_W - 1;
    localparam int TAIL_BIT = FLIT_W - 2;
    localparam int DX_LSB   = PAYLOAD_W + COORD_W;
    localparam int DY_LSB   = PAYLOAD_W;

    logic [FLIT_W-1:0]    front;
    logic                 empty;
    logic [NUM_PORTS-1:0] rc_port;
    logic                 credit_q;

    vcic_fifo #(.DATA_W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_data (in_flit),
        .rd_en   (deq),
        .front   (front),
        .empty   (empty),
        .full    (in_full)
    );

    vcic_route #(.COORD_W(COORD_W), .CUR_X(CUR_X), .CUR_Y(CUR_Y)) u_route (
        .dest_x (front[DX_LSB +: COORD_W]),
        .dest_y (front[DY_LSB +: COORD_W]),
        .port   (rc_port)
    );

    vcic_ctrl #(.NUM_OVC(NUM_OVC), .VC_W(VC_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .front_valid (!empty),
        .front_head  (front[HEAD_BIT]),
        .front_tail  (front[TAIL_BIT]),
        .rc_port     (rc_port),
        .va_grant    (va_grant),
        .sa_grant    (sa_grant),
        .va_req      (va_req),
        .sa_req      (sa_req),
        .req_port    (req_port),
        .req_vc      (req_vc),
        .deq         (deq)
    );

    assign out_flit   = front;
    assign credit_out = credit_q;

    // Credit return: one registered pulse per dequeue.
    always_ff @(posedge clk) begin
        if (!rst_n) credit_q <= 1'b0;
        else        credit_q <= deq;
    end

    AST_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        deq |=> credit_out); // R8
    AST_NO_SPURIOUS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        !deq |=> !credit_out); // R8
endmodule

// File: tb/sim_vc_input_ctrl.sv
// Bench: random packets and grants against a reference model of the
// requirements, plus directed full-queue and always-grant phases.
module sim_vc_input_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 16;
    localparam int QD = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [FW-1:0] in_flit;
    logic          in_full;
    logic          credit_out;
    logic          va_req;
    logic          sa_req;
    logic [4:0]    req_port;
    logic [1:0]    req_vc;
    logic [3:0]    va_grant;
    logic          sa_grant;
    logic          deq;
    logic [FW-1:0] out_flit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    vc_input_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_full(in_full), .credit_out(credit_out), .va_req(va_req),
        .sa_req(sa_req), .req_port(req_port), .req_vc(req_vc),
        .va_grant(va_grant), .sa_grant(sa_grant), .deq(deq), .out_flit(out_flit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model state
    logic [FW-1:0] mq [$];
    int            m_state;   // 0 idle, 1 routed, 2 active
    logic [4:0]    m_port;
    logic [1:0]    m_vc;
    bit            m_prev_deq;
    bit            m_prev_tail_deq;
    // Packet generator state
    int            g_left;
    logic [2:0]    g_dx, g_dy;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] xy(input logic [2:0] dx, input logic [2:0] dy);
        if (dx > 3'd3) return 5'b00010;
        if (dx < 3'd3) return 5'b00100;
        if (dy > 3'd3) return 5'b01000;
        if (dy < 3'd3) return 5'b10000;
        return 5'b00001;
    endfunction

    function automatic logic [1:0] enc(input logic [3:0] g);
        for (int i = 0; i < 4; i++) if (g[i]) return 2'(i);
        return 2'd0;
    endfunction

    function automatic logic [FW-1:0] next_flit();
        logic h, t;
        if (g_left == 0) begin
            g_left = 1 + int'($urandom % 4);
            g_dx = 3'($urandom);
            g_dy = 3'($urandom);
            h = 1'b1;
        end else h = 1'b0;
        t = (g_left == 1);
        g_left--;
        return {h, t, g_dx, g_dy, 8'($urandom)};
    endfunction

    // mode 0: random; 1: grants always; 2: no grants
    task automatic run(input int mode, input int n);
        for (int c = 0; c < n; c++) begin
            bit e_va, e_sa, e_deq, f_ok, f_head, f_tail;
            logic [4:0] e_port;
            logic [1:0] e_vc;
            logic [FW-1:0] fr;
            @(negedge clk);
            if (int'(mq.size()) < QD && ($urandom % 4 != 0 || mode == 2)) begin
                in_valid = 1'b1;
                in_flit = next_flit();
            end else begin
                in_valid = 1'b0;
                in_flit = '0;
            end
            if (mode == 1) begin
                va_grant = 4'b1 << ($urandom % 4);
                sa_grant = 1'b1;
            end else if (mode == 2) begin
                va_grant = 4'b0;
                sa_grant = 1'b0;
            end else begin
                va_grant = ($urandom % 2) ? (4'b1 << ($urandom % 4)) : 4'b0;
                sa_grant = ($urandom % 5) < 3;
            end
            #1;
            f_ok = mq.size() > 0;
            fr = f_ok ? mq[0] : '0;
            f_head = fr[15];
            f_tail = fr[14];
            e_va = 0; e_sa = 0; e_deq = 0; e_port = '0; e_vc = '0;
            if (m_state == 1) begin
                e_va = 1; e_sa = 1; e_port = m_port; e_vc = enc(va_grant);
                e_deq = (|va_grant) && sa_grant;
            end else if (m_state == 2 && f_ok) begin
                e_sa = 1; e_port = m_port; e_vc = m_vc; e_deq = sa_grant;
            end
            chk(in_full == (mq.size() == QD), "R2", "in_full", in_full, mq.size() == QD);
            chk(va_req == e_va, "R4", "va_req", va_req, e_va);
            chk(sa_req == e_sa, "R6", "sa_req", sa_req, e_sa);
            chk(req_port == e_port, "R3", "req_port", req_port, e_port);
            chk(req_vc == e_vc, "R5", "req_vc", req_vc, e_vc);
            chk(deq == e_deq, "R5", "deq", deq, e_deq);
            chk(credit_out == m_prev_deq, "R8", "credit_out", credit_out, m_prev_deq);
            if (e_deq) chk(out_flit == fr, "R9", "out_flit", out_flit, fr);
            if (m_prev_tail_deq && f_ok)
                chk(!sa_req && !va_req, "R7", "request after tail", {va_req, sa_req}, 0);
            // Model next state
            case (m_state)
                0: if (f_ok && f_head) begin m_state = 1; m_port = xy(fr[13:11], fr[10:8]); end
                1: begin
                    if (e_deq && f_tail) begin m_state = 0; m_port = '0; m_vc = '0; end
                    else if (|va_grant) begin m_state = 2; m_vc = enc(va_grant); end
                end
                default: if (e_deq && f_tail) begin m_state = 0; m_port = '0; m_vc = '0; end
            endcase
            m_prev_deq = e_deq;
            m_prev_tail_deq = e_deq && f_tail;
            @(posedge clk);
            if (e_deq) void'(mq.pop_front());
            if (in_valid) mq.push_back(in_flit);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; in_valid = 1'b0; in_flit = '0; va_grant = '0; sa_grant = 1'b0;
        m_state = 0; m_port = '0; m_vc = '0; m_prev_deq = 0; m_prev_tail_deq = 0;
        g_left = 0; g_dx = '0; g_dy = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!va_req && !sa_req && !deq, "R1", "requests in reset", {va_req, sa_req, deq}, 0);
        chk(req_port == 0 && req_vc == 0, "R1", "port/vc in reset", {req_port, req_vc}, 0);
        chk(!credit_out && !in_full, "R1", "credit/full in reset", {credit_out, in_full}, 0);
        rst_n = 1'b1;
        #1;
        chk(!va_req && !sa_req && !in_full, "R1", "first cycle after reset", {va_req, sa_req, in_full}, 0);
        run(2, 12);     // fill queue, no grants: R2, R4 hold
        run(1, 60);     // drain with full grants: R7 gap
        run(0, 4000);   // random mix
        run(1, 40);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule